// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Receive Frame Checker

This block sits behind a symbol decoder on a variable-pulse-width vehicle bus. Each cycle it may receive one classified symbol event. It also receives a strobe carrying each assembled received byte. From these two streams it checks the structure of a frame. A frame is a message opened by a start-of-frame symbol. It may carry one in-frame response segment, which is opened by a normalization bit. The block counts the bytes received, runs a CRC over each segment and checks the CRC at each accepted end-of-data.

A fault produces a single-cycle invalid-frame or CRC-failure pulse, so that a separate status register can latch it. It also produces a pulse asking transmit logic to drop the queued transmits for the current frame. After a fault the receiver is closed until the end-of-frame minimum arrives. A break symbol is reported once per frame, asks for every queued transmit to be cancelled, and also closes the receiver until the end of the frame. While the unit is in sleep or filter mode and is not transmitting, the fault pulses are held back, but the frame is still abandoned.

Top module: `vpw_frame_check`

## Requirements
- R1: While `rst_n` or `en` is low, every pulse output is low, `rx_open` is high and the checker returns to waiting for a start of frame. A symbol takes effect when `sym_valid` is high, and the pulses it causes appear in the following cycle. The symbol codes are 0 start of frame, 1 data zero, 2 data one, 3 end-of-data minimum, 4 end-of-frame minimum, 5 break and 6 normalization bit.
- R2: The CRC uses the polynomial x^8+x^4+x^3+x^2+1 with its register preset to 0xFF, and it runs over the bytes strobed since the last start of frame, normalization bit or accepted end of data. At an end-of-data symbol, a remainder other than 0xC4 gives a one-cycle `crc_fail_pulse`.
- R3: A response segment opened by a normalization bit after the first end of data gets the same CRC check at its own end of data.
- R4: A start of frame that arrives after an accepted end of data but before the end-of-frame minimum gives `bad_frame_pulse`.
- R5: While data bits are expected, a start of frame, end-of-frame or normalization symbol gives `bad_frame_pulse`. Data bits are expected right after a start of frame or normalization bit, or while a byte is partly received. An end-of-data symbol also gives `bad_frame_pulse` when the segment holds no complete byte or stops partway through a byte.
- R6: A data zero or data one symbol that arrives while a start of frame is expected gives `bad_frame_pulse`.
- R7: After the second accepted end of data in a frame, any symbol other than end-of-frame minimum or break, including a normalization bit, gives `bad_frame_pulse`.
- R8: With `len_check_off` low, the first data bit after 12 bytes have been strobed in the frame gives `bad_frame_pulse`. With `len_check_off` high, no length fault is raised.
- R9: A frame raises at most one invalid-frame or CRC fault. The fault pulses `cancel_frame_tx` in the same cycle and drops `rx_open`. Every later symbol except break is ignored until end-of-frame minimum, which raises `rx_open` again.
- R10: While `quiet_mode` is high and `tx_active` is low, the invalid-frame and CRC pulses are suppressed, but `cancel_frame_tx` and the lockout still happen. With `tx_active` high the fault pulses are reported.
- R11: The first break in a frame gives `break_pulse` and `cancel_all_tx` together, drops `rx_open`, and is followed by no further break pulse until end-of-frame minimum.
- R12: A byte strobe that arrives in the same cycle as the end-of-data symbol is folded into the CRC before the check is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Checker enable; low holds the checker cleared |
| sym_valid | input | 1 | A symbol event is present this cycle |
| sym_code | input | 3 | Symbol code (see R1) |
| rx_byte_valid | input | 1 | Assembled byte strobe |
| rx_byte | input | 8 | Assembled received byte |
| quiet_mode | input | 1 | Unit is in sleep or filter mode |
| tx_active | input | 1 | Unit is currently transmitting |
| len_check_off | input | 1 | High disables the 12-byte length check |
| rx_open | output | 1 | Receiver accepting symbols (low during lockout) |
| bad_frame_pulse | output | 1 | One-cycle invalid-frame event |
| crc_fail_pulse | output | 1 | One-cycle CRC failure event |
| break_pulse | output | 1 | One-cycle break event |
| cancel_frame_tx | output | 1 | Drop queued transmits for this frame |
| cancel_all_tx | output | 1 | Drop every queued transmit |

## Verification
The last byte strobe of a segment can fall in the same cycle as the end-of-data symbol. In that cycle the CRC update and the CRC check must both act. The bench provokes this through table rows that merge the final check-byte strobe into the end-of-data cycle, once with a correct check byte and once with a check byte that has one bit flipped. Each case is judged by counting `crc_fail_pulse` over the frame against a CRC the bench computes bit by bit, and by checking that `rx_open` is high again after end of frame.

// File: rtl/vpw_fc_pkg.sv
package vpw_fc_pkg;

  typedef enum logic [2:0] {
    SYM_SOF  = 3'd0,
    SYM_D0   = 3'd1,
    SYM_D1   = 3'd2,
    SYM_EODM = 3'd3,
    SYM_EOFM = 3'd4,
    SYM_BRK  = 3'd5,
    SYM_NB   = 3'd6
  } sym_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_GAP,
    ST_LOCK
  } fc_state_e;

  // One byte through an MSB-first CRC-8 (no reflection).
  function automatic logic [7:0] crc8_step(input logic [7:0] c,
                                           input logic [7:0] d,
                                           input logic [7:0] poly);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/vpw_fc_crc.sv
module vpw_fc_crc #(
  parameter logic [7:0] CRC_POLY    = 8'h1D,
  parameter logic [7:0] CRC_INIT    = 8'hFF,
  parameter logic [7:0] CRC_RESIDUE = 8'hC4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] byte_in,
  output logic       pass_now
);
  import vpw_fc_pkg::*;

  logic [7:0] crc_r;
  logic [7:0] crc_with_byte;

  // The check sees a byte strobed in the same cycle (R12).
  assign crc_with_byte = upd ? crc8_step(crc_r, byte_in, CRC_POLY) : crc_r;
  assign pass_now      = (crc_with_byte == CRC_RESIDUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_r <= CRC_INIT;
    else if (clr) crc_r <= CRC_INIT;
    else if (upd) crc_r <= crc_with_byte;
  end

endmodule

// File: rtl/vpw_fc_len.sv
module vpw_fc_len #(
  parameter int MAX_BYTES = 12,
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_frame,
  input  logic clr_seg,
  input  logic bit_acc,
  input  logic byte_acc,
  output logic seg_has_byte,
  output logic mid_byte,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam int PW = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
  localparam logic [CW-1:0] LIMIT    = CW'(MAX_BYTES);
  localparam logic [PW-1:0] LAST_BIT = PW'(BYTE_BITS - 1);

  logic [CW-1:0] frame_cnt;
  logic          seg_seen;
  logic [PW-1:0] bit_ph;

  assign at_limit     = (frame_cnt >= LIMIT);
  assign seg_has_byte = seg_seen || byte_acc;
  assign mid_byte     = (bit_ph != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      seg_seen  <= 1'b0;
      bit_ph    <= '0;
    end else begin
      if (clr_frame)                  frame_cnt <= '0;
      else if (byte_acc && !at_limit) frame_cnt <= frame_cnt + 1'b1;

      if (clr_seg)       seg_seen <= 1'b0;
      else if (byte_acc) seg_seen <= 1'b1;

      if (clr_seg)      bit_ph <= '0;
      else if (bit_acc) bit_ph <= (bit_ph == LAST_BIT) ? '0 : bit_ph + 1'b1;
    end
  end

endmodule

// File: rtl/vpw_fc_seq.sv
module vpw_fc_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sym_valid,
  input  logic [2:0] sym_code,
  input  logic       byte_valid,
  input  logic       quiet_mode,
  input  logic       tx_active,
  input  logic       len_check_off,
  input  logic       seg_has_byte,
  input  logic       mid_byte,
  input  logic       at_limit,
  input  logic       crc_pass,
  output logic       clr_frame,
  output logic       clr_seg,
  output logic       bit_acc,
  output logic       byte_acc,
  output logic       rx_open,
  output logic       bad_frame_pulse,
  output logic       crc_fail_pulse,
  output logic       break_pulse,
  output logic       cancel_frame_tx,
  output logic       cancel_all_tx
);
  import vpw_fc_pkg::*;

  fc_state_e  state, nxt;
  logic [1:0] eod_cnt, nxt_eod;
  logic       brk_done, nxt_brk;
  logic       ev_bad, ev_crc, ev_brk;
  logic       is_bit, is_sof, is_eodm, is_eofm, is_nb, is_brk;
  logic       suppress;

  assign is_sof  = sym_valid && (sym_code == SYM_SOF);
  assign is_bit  = sym_valid && ((sym_code == SYM_D0) || (sym_code == SYM_D1));
  assign is_eodm = sym_valid && (sym_code == SYM_EODM);
  assign is_eofm = sym_valid && (sym_code == SYM_EOFM);
  assign is_nb   = sym_valid && (sym_code == SYM_NB);
  assign is_brk  = sym_valid && (sym_code == SYM_BRK);
  assign suppress = quiet_mode && !tx_active;
  assign rx_open  = (state != ST_LOCK);
  assign byte_acc = en && byte_valid && (state == ST_DATA);

  always_comb begin
    nxt       = state;
    nxt_eod   = eod_cnt;
    nxt_brk   = brk_done;
    ev_bad    = 1'b0;
    ev_crc    = 1'b0;
    ev_brk    = 1'b0;
    clr_frame = 1'b0;
    clr_seg   = 1'b0;
    bit_acc   = 1'b0;
    if (!en) begin
      nxt       = ST_IDLE;
      nxt_eod   = 2'd0;
      nxt_brk   = 1'b0;
      clr_frame = 1'b1;
      clr_seg   = 1'b1;
    end else if (is_brk && !brk_done) begin
      ev_brk = 1'b1;                         // R11
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (is_sof) begin
            nxt       = ST_DATA;
            nxt_eod   = 2'd0;
            clr_frame = 1'b1;
            clr_seg   = 1'b1;
          end else if (is_bit) begin
            ev_bad = 1'b1;                   // R6
          end
        end
        ST_DATA: begin
          if (is_bit) begin
            if (at_limit && !len_check_off) ev_bad = 1'b1;  // R8
            else                            bit_acc = 1'b1;
          end else if (is_eodm) begin
            if (!seg_has_byte || mid_byte) ev_bad = 1'b1;   // R5
            else if (!crc_pass)            ev_crc = 1'b1;   // R2, R3
            else begin
              nxt     = ST_GAP;
              clr_seg = 1'b1;
              nxt_eod = (eod_cnt == 2'd3) ? eod_cnt : eod_cnt + 2'd1;
            end
          end else if (is_sof || is_eofm || is_nb) begin
            ev_bad = 1'b1;                   // R5
          end
        end
        ST_GAP: begin
          if (is_eofm) begin
            nxt = ST_IDLE;
          end else if (is_nb && (eod_cnt < 2'd2)) begin
            nxt     = ST_DATA;               // R3: response segment
            clr_seg = 1'b1;
          end else if (sym_valid && !is_brk) begin
            ev_bad = 1'b1;                   // R4, R7
          end
        end
        ST_LOCK: begin
          if (is_eofm) begin
            nxt     = ST_IDLE;
            nxt_brk = 1'b0;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
    if (ev_brk) begin
      nxt     = ST_LOCK;
      nxt_brk = 1'b1;
    end
    if (ev_bad || ev_crc) nxt = ST_LOCK;     // R9
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      eod_cnt         <= 2'd0;
      brk_done        <= 1'b0;
      bad_frame_pulse <= 1'b0;
      crc_fail_pulse  <= 1'b0;
      break_pulse     <= 1'b0;
      cancel_frame_tx <= 1'b0;
      cancel_all_tx   <= 1'b0;
    end else begin
      state           <= nxt;
      eod_cnt         <= nxt_eod;
      brk_done        <= nxt_brk;
      bad_frame_pulse <= ev_bad && !suppress;   // R10
      crc_fail_pulse  <= ev_crc && !suppress;
      break_pulse     <= ev_brk;
      cancel_frame_tx <= ev_bad || ev_crc;
      cancel_all_tx   <= ev_brk;
    end
  end

  // R9: a fault is a single pulse and leaves the receiver closed
  a_r9_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_frame_pulse || crc_fail_pulse) |=> !(bad_frame_pulse || crc_fail_pulse));
  a_r9_cancel_closes: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_frame_tx |-> !rx_open);
  a_r9_close_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_open) |-> (cancel_frame_tx || cancel_all_tx));
  // R10: no fault pulse when the previous cycle was quiet and idle
  a_r10_quiet_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_frame_pulse || crc_fail_pulse) |-> $past(!quiet_mode || tx_active));
  // R11: break reported once, with the cancel-all request
  a_r11_break_once: assert property (@(posedge clk) disable iff (!rst_n)
    break_pulse |=> !break_pulse);
  a_r11_break_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    break_pulse |-> (cancel_all_tx && !rx_open));
  // R1: disabled checker stays silent and open
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bad_frame_pulse && !crc_fail_pulse && !break_pulse &&
             !cancel_frame_tx && !cancel_all_tx && rx_open));

endmodule

// File: rtl/vpw_frame_check.sv
module vpw_frame_check #(
  parameter int         MAX_BYTES   = 12,
  parameter int         BYTE_BITS   = 8,
  parameter logic [7:0] CRC_POLY    = 8'h1D,
  parameter logic [7:0] CRC_INIT    = 8'hFF,
  parameter logic [7:0] CRC_RESIDUE = 8'hC4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sym_valid,
  input  logic [2:0] sym_code,
  input  logic       rx_byte_valid,
  input  logic [7:0] rx_byte,
  input  logic       quiet_mode,
  input  logic       tx_active,
  input  logic       len_check_off,
  output logic       rx_open,
  output logic       bad_frame_pulse,
  output logic       crc_fail_pulse,
  output logic       break_pulse,
  output logic       cancel_frame_tx,
  output logic       cancel_all_tx
);

  logic clr_frame, clr_seg, bit_acc, byte_acc;
  logic seg_has_byte, mid_byte, at_limit, crc_pass;

  vpw_fc_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .en              (en),
    .sym_valid       (sym_valid),
    .sym_code        (sym_code),
    .byte_valid      (rx_byte_valid),
    .quiet_mode      (quiet_mode),
    .tx_active       (tx_active),
    .len_check_off   (len_check_off),
    .seg_has_byte    (seg_has_byte),
    .mid_byte        (mid_byte),
    .at_limit        (at_limit),
    .crc_pass        (crc_pass),
    .clr_frame       (clr_frame),
    .clr_seg         (clr_seg),
    .bit_acc         (bit_acc),
    .byte_acc        (byte_acc),
    .rx_open         (rx_open),
    .bad_frame_pulse (bad_frame_pulse),
    .crc_fail_pulse  (crc_fail_pulse),
    .break_pulse     (break_pulse),
    .cancel_frame_tx (cancel_frame_tx),
    .cancel_all_tx   (cancel_all_tx)
  );

  vpw_fc_len #(
    .MAX_BYTES (MAX_BYTES),
    .BYTE_BITS (BYTE_BITS)
  ) u_len (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_frame    (clr_frame),
    .clr_seg      (clr_seg),
    .bit_acc      (bit_acc),
    .byte_acc     (byte_acc),
    .seg_has_byte (seg_has_byte),
    .mid_byte     (mid_byte),
    .at_limit     (at_limit)
  );

  vpw_fc_crc #(
    .CRC_POLY    (CRC_POLY),
    .CRC_INIT    (CRC_INIT),
    .CRC_RESIDUE (CRC_RESIDUE)
  ) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_seg),
    .upd      (byte_acc),
    .byte_in  (rx_byte),
    .pass_now (crc_pass)
  );

  // R8: the sequencer never accepts a bit past the limit while the check is on
  a_r8_len_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_acc && at_limit) |-> len_check_off);

endmodule

// File: tb/vpw_frame_check_tb_top.sv
module vpw_frame_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam logic [2:0] C_SOF = 3'd0, C_D0 = 3'd1, C_D1 = 3'd2, C_EODM = 3'd3,
                         C_EOFM = 3'd4, C_BRK = 3'd5, C_NB = 3'd6;

  // {exp_crc, exp_bad, coincide, len_off, corrupt, payload_len[4:0]}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd5},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd11},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd12},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd12},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd4},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'd4},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd13}
  };

  logic clk = 1'b0;
  logic rst_n, en, sym_valid, rx_byte_valid, quiet_mode, tx_active, len_check_off;
  logic [2:0] sym_code;
  logic [7:0] rx_byte;
  logic rx_open, bad_frame_pulse, crc_fail_pulse, break_pulse, cancel_frame_tx, cancel_all_tx;

  int total = 0, bad = 0;
  int n_bad = 0, n_crc = 0, n_brk = 0, n_cf = 0, n_ca = 0;
  int s_bad, s_crc, s_brk, s_cf, s_ca;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vpw_frame_check dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .sym_valid(sym_valid), .sym_code(sym_code),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .quiet_mode(quiet_mode),
    .tx_active(tx_active), .len_check_off(len_check_off), .rx_open(rx_open),
    .bad_frame_pulse(bad_frame_pulse), .crc_fail_pulse(crc_fail_pulse),
    .break_pulse(break_pulse), .cancel_frame_tx(cancel_frame_tx),
    .cancel_all_tx(cancel_all_tx));

  always @(negedge clk) begin
    if (bad_frame_pulse) n_bad++;
    if (crc_fail_pulse)  n_crc++;
    if (break_pulse)     n_brk++;
    if (cancel_frame_tx) n_cf++;
    if (cancel_all_tx)   n_ca++;
  end

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h1D;
    end
    return c;
  endfunction

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'((s * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    s_bad = n_bad; s_crc = n_crc; s_brk = n_brk; s_cf = n_cf; s_ca = n_ca;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_sym(input logic [2:0] c);
    sym_valid = 1'b1; sym_code = c;
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_sym(b[i] ? C_D1 : C_D0);
  endtask

  task automatic strobe(input logic [7:0] b);
    rx_byte_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_byte_valid = 1'b0;
  endtask

  // Bytes, check byte and end-of-data for one segment.
  task automatic send_seg(input int n, input int seed, input bit corrupt, input bit coinc);
    logic [7:0] c, b;
    c = 8'hFF;
    for (int k = 0; k < n; k++) begin
      b = pat(seed, k);
      c = ref_crc(c, b);
      send_bits(b);
      strobe(b);
    end
    c = ~c ^ (corrupt ? 8'h01 : 8'h00);
    send_bits(c);
    if (coinc) begin
      rx_byte_valid = 1'b1; rx_byte = c; sym_valid = 1'b1; sym_code = C_EODM;
      @(negedge clk);
      rx_byte_valid = 1'b0; sym_valid = 1'b0;
    end else begin
      strobe(c);
      send_sym(C_EODM);
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; sym_valid = 1'b0; sym_code = 3'd0; rx_byte_valid = 1'b0;
    rx_byte = 8'd0; quiet_mode = 1'b0; tx_active = 1'b0; len_check_off = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(rx_open, 1, "R1 rx_open after reset");
    chk(bad_frame_pulse + crc_fail_pulse + break_pulse + cancel_frame_tx + cancel_all_tx,
        0, "R1 pulses after reset");

    // Table: R2 CRC, R8 length, R12 coincident strobe
    for (int i = 0; i < NV; i++) begin
      snap();
      len_check_off = VEC[i][6];
      send_sym(C_SOF);
      send_seg(int'(VEC[i][4:0]), i, VEC[i][5], VEC[i][7]);
      send_sym(C_EOFM);
      idle(2);
      chk(n_bad - s_bad, int'(VEC[i][8]), $sformatf("R8 R12 vec%0d bad_frame", i));
      chk(n_crc - s_crc, int'(VEC[i][9]), $sformatf("R2 R12 vec%0d crc_fail", i));
      chk(rx_open, 1, $sformatf("R9 vec%0d reopened", i));
    end
    len_check_off = 1'b0;

    // R6 data bit while waiting for start of frame
    snap(); send_sym(C_D1); idle(1);
    chk(n_bad - s_bad, 1, "R6 bit before SOF");
    chk(rx_open, 0, "R9 closed after fault");
    // R9 further faults ignored while locked
    send_sym(C_D0); send_sym(C_SOF); send_sym(C_NB); send_sym(C_EODM); idle(1);
    chk(n_bad - s_bad, 1, "R9 single fault per frame");
    chk(n_cf - s_cf, 1, "R9 cancel_frame once");
    chk(n_ca - s_ca, 0, "R9 no cancel_all");
    send_sym(C_EOFM); idle(1);
    chk(rx_open, 1, "R9 reopened by EOFM");

    // R4 SOF between end of data and end of frame
    snap(); send_sym(C_SOF); send_seg(2, 20, 1'b0, 1'b0); send_sym(C_SOF); idle(1);
    chk(n_bad - s_bad, 1, "R4 SOF in gap");
    send_sym(C_EOFM);

    // R5 SOF while data expected
    snap(); send_sym(C_SOF); send_sym(C_SOF); idle(1);
    chk(n_bad - s_bad, 1, "R5 SOF during data");
    send_sym(C_EOFM);
    // R5 end of data part way through a byte
    snap(); send_sym(C_SOF); send_sym(C_D1); send_sym(C_D0); send_sym(C_D1);
    send_sym(C_EODM); idle(1);
    chk(n_bad - s_bad, 1, "R5 EODM mid byte");
    send_sym(C_EOFM);
    // R5 end of data with no byte at all
    snap(); send_sym(C_SOF); send_sym(C_EODM); idle(1);
    chk(n_bad - s_bad, 1, "R5 EODM with empty segment");
    send_sym(C_EOFM);

    // R3 response segment: good and corrupted
    snap(); send_sym(C_SOF); send_seg(3, 30, 1'b0, 1'b0); send_sym(C_NB);
    send_seg(2, 31, 1'b0, 1'b0); send_sym(C_EOFM); idle(1);
    chk(n_bad - s_bad + n_crc - s_crc, 0, "R3 good response");
    snap(); send_sym(C_SOF); send_seg(3, 32, 1'b0, 1'b0); send_sym(C_NB);
    send_seg(2, 33, 1'b1, 1'b0); idle(1);
    chk(n_crc - s_crc, 1, "R3 bad response CRC");
    send_sym(C_EOFM);

    // R7 second end of data followed by a normalization bit
    snap(); send_sym(C_SOF); send_seg(1, 40, 1'b0, 1'b0); send_sym(C_NB);
    send_seg(1, 41, 1'b0, 1'b0); send_sym(C_NB); idle(1);
    chk(n_bad - s_bad, 1, "R7 NB after second EOD");
    send_sym(C_EOFM);

    // R10 quiet and idle: pulse suppressed, lockout still taken
    quiet_mode = 1'b1; tx_active = 1'b0;
    snap(); send_sym(C_D0); idle(1);
    chk(n_bad - s_bad, 0, "R10 suppressed fault");
    chk(n_cf - s_cf, 1, "R10 cancel still issued");
    chk(rx_open, 0, "R10 lockout still taken");
    send_sym(C_EOFM);
    tx_active = 1'b1;
    snap(); send_sym(C_D0); idle(1);
    chk(n_bad - s_bad, 1, "R10 reported while transmitting");
    send_sym(C_EOFM);
    quiet_mode = 1'b0; tx_active = 1'b0;

    // R11 break during a frame, repeated break, new frame
    snap(); send_sym(C_SOF); send_sym(C_D1); send_sym(C_BRK); idle(1);
    chk(n_brk - s_brk, 1, "R11 break reported");
    chk(n_ca - s_ca, 1, "R11 cancel_all");
    chk(rx_open, 0, "R11 closed after break");
    send_sym(C_BRK); send_sym(C_BRK); idle(1);
    chk(n_brk - s_brk, 1, "R11 break once per frame");
    send_sym(C_EOFM); idle(1);
    chk(rx_open, 1, "R11 reopened");
    send_sym(C_BRK); idle(1);
    chk(n_brk - s_brk, 2, "R11 break in next frame");
    send_sym(C_EOFM);

    // R1 disable mid frame clears and silences the checker
    snap(); send_sym(C_SOF); send_sym(C_D1); en = 1'b0;
    send_sym(C_D1); send_sym(C_SOF); idle(1);
    chk(n_bad - s_bad, 0, "R1 silent while disabled");
    chk(rx_open, 1, "R1 open while disabled");
    en = 1'b1;
    send_sym(C_SOF); send_seg(2, 50, 1'b0, 1'b0); send_sym(C_EOFM); idle(1);
    chk(n_bad - s_bad + n_crc - s_crc, 0, "R1 clean frame after enable");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule